// File: doc/BRIEF.md
# Double-Precision Predicated Compare Unit

This unit compares two IEEE-754 binary64 values under a 5-bit predicate code and returns a 64-bit mask: all ones when the predicate holds, all zeros when it does not. The mask lands in the low 64 bits of a wide result word. The bits above it are filled according to a mode input.

In legacy mode only the three low predicate bits count. The upper part of the result is passed through from the first operand word, which plays the role of the destination. In extended mode all five predicate bits count. Bits 127:64 are copied from the first operand word and everything above bit 127 is cleared.

Alongside the mask, the unit reports an invalid-operation flag and a denormal-operand flag. The result is registered, so it appears one clock after the operands are presented with `in_valid`.

Top module: `dpcmp_unit`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. Result and flags then reflect the inputs sampled at that edge. Reset drives `out_valid`, `result`, `flag_invalid` and `flag_denormal` to 0.
- R2: `result[63:0]` is always either all ones (predicate true) or all zeros (predicate false).
- R3: Ordering follows value, with the sign bit 63 and magnitude bits 62:0 deciding. Both infinities are ordered, and -0.0 equals +0.0 under every predicate.
- R4: An operand is a NaN when bits 62:52 are all ones and bits 51:0 are nonzero. It is quiet when bit 51 is 1 and signaling when bit 51 is 0. Code 3 is true exactly when either operand is a NaN, and code 7 is true exactly when neither is.
- R5: Codes 0 to 15 evaluate as follows. The first eight codes are:
  - 0 equal
  - 1 less
  - 2 less-or-equal
  - 3 unordered
  - 4 not-equal
  - 5 not-less
  - 6 not-less-or-equal
  - 7 ordered

  The next eight codes are:
  - 8 equal-or-unordered
  - 9 not-greater-or-equal
  - 10 not-greater
  - 11 always false
  - 12 ordered-and-not-equal
  - 13 greater-or-equal
  - 14 greater
  - 15 always true

  With a NaN operand, codes 4, 5, 6, 8, 9 and 10 give true, and codes 0, 1, 2, 12, 13 and 14 give false.
- R6: In extended mode, code 16+k gives the same mask as code k, for k from 0 to 15.
- R7: In legacy mode, predicate bits 4:3 are ignored and `result[DEST_W-1:64]` equals `src_a[DEST_W-1:64]`.
- R8: In extended mode, `result[127:64]` equals `src_a[127:64]` and `result[DEST_W-1:128]` is zero.
- R9: The attribute is signaling for low-nibble codes 1, 2, 5, 6, 9, 10, 13 and 14, and quiet for the rest. In extended mode, predicate bit 4 inverts the attribute. `flag_invalid` is set when either operand is a signaling NaN, or when either operand is a quiet NaN and the attribute is signaling.
- R10: `flag_denormal` is set when either operand has bits 62:52 zero and bits 51:0 nonzero.
- R11: Both flags are 0 in any cycle where `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and predicate are valid this cycle |
| ext_mode | input | 1 | 1 selects extended mode, 0 selects legacy mode |
| pred | input | 5 | Predicate code |
| src_a | input | DEST_W | First operand word; bits 63:0 are the first value |
| src_b | input | 64 | Second value |
| out_valid | output | 1 | Result and flags are valid |
| result | output | DEST_W | Mask in bits 63:0, upper part per mode |
| flag_invalid | output | 1 | Invalid-operation status |
| flag_denormal | output | 1 | Denormal-operand status |

## Verification
The bench builds the unit with the default `DEST_W` of 256. This leaves 128 bits above the copied lane, so both the legacy pass-through of a full upper word and the extended-mode clearing above bit 127 are visible at the port.

Random operands are drawn from classes that include both signed zeros, both infinities, quiet and signaling NaNs, subnormals, and pairs that are equal or differ by one unit. All 32 codes are drawn in both modes. This makes every ordered/unordered and quiet/signaling combination reachable.

// File: rtl/dpcmp_pkg.sv
package dpcmp_pkg;
  localparam int FP_W    = 64;
  localparam int EXP_W   = 11;
  localparam int FRAC_W  = 52;
  localparam int MAG_W   = FP_W - 1;
  localparam int PRED_W  = 5;
  localparam int BASE_W  = PRED_W - 1;
  localparam int LEG_W   = 3;

  typedef struct packed {
    logic is_nan;
    logic is_snan;
    logic is_qnan;
    logic is_zero;
    logic is_sub;
  } fp_class_t;

  typedef enum logic [BASE_W-1:0] {
    P_EQ     = 4'd0,
    P_LT     = 4'd1,
    P_LE     = 4'd2,
    P_UNORD  = 4'd3,
    P_NE     = 4'd4,
    P_NLT    = 4'd5,
    P_NLE    = 4'd6,
    P_ORD    = 4'd7,
    P_EQ_U   = 4'd8,
    P_NGE    = 4'd9,
    P_NGT    = 4'd10,
    P_NEVER  = 4'd11,
    P_NE_O   = 4'd12,
    P_GE     = 4'd13,
    P_GT     = 4'd14,
    P_ALWAYS = 4'd15
  } base_pred_e;

  function automatic fp_class_t classify(input logic [FP_W-1:0] v);
    fp_class_t c;
    logic exp_ones, exp_zero, frac_nz;
    exp_ones  = &v[FP_W-2:FRAC_W];
    exp_zero  = ~|v[FP_W-2:FRAC_W];
    frac_nz   = |v[FRAC_W-1:0];
    c.is_nan  = exp_ones & frac_nz;
    c.is_qnan = c.is_nan & v[FRAC_W-1];
    c.is_snan = c.is_nan & ~v[FRAC_W-1];
    c.is_zero = exp_zero & ~frac_nz;
    c.is_sub  = exp_zero & frac_nz;
    return c;
  endfunction

  // Signed less-than on two non-NaN values, zeros treated as equal.
  function automatic logic signed_less(input logic [FP_W-1:0] a,
                                       input logic [FP_W-1:0] b,
                                       input logic both_zero);
    logic [MAG_W-1:0] ma, mb;
    logic r;
    ma = a[MAG_W-1:0];
    mb = b[MAG_W-1:0];
    if (both_zero)                r = 1'b0;
    else if (a[FP_W-1] != b[FP_W-1]) r = a[FP_W-1];
    else if (a[FP_W-1])           r = (mb < ma);
    else                          r = (ma < mb);
    return r;
  endfunction

  function automatic logic base_signaling(input logic [BASE_W-1:0] b);
    return b[0] ^ b[1];
  endfunction
endpackage

// File: rtl/dpcmp_classify.sv
module dpcmp_classify
  import dpcmp_pkg::*;
(
  input  logic [FP_W-1:0] value,
  output fp_class_t       cls
);
  always_comb cls = classify(value);
endmodule

// File: rtl/dpcmp_order.sv
module dpcmp_order
  import dpcmp_pkg::*;
(
  input  logic [FP_W-1:0] a,
  input  logic [FP_W-1:0] b,
  input  logic            a_nan,
  input  logic            b_nan,
  input  logic            a_zero,
  input  logic            b_zero,
  output logic            unord,
  output logic            eq,
  output logic            lt
);
  logic both_zero;
  always_comb begin
    both_zero = a_zero & b_zero;
    unord     = a_nan | b_nan;
    eq        = ~unord & ((a == b) | both_zero);
    lt        = ~unord & signed_less(a, b, both_zero);
  end
endmodule

// File: rtl/dpcmp_predicate.sv
module dpcmp_predicate
  import dpcmp_pkg::*;
(
  input  logic [PRED_W-1:0] code,
  input  logic              unord,
  input  logic              eq,
  input  logic              lt,
  output logic              holds,
  output logic              signaling
);
  base_pred_e base;
  always_comb begin
    base      = base_pred_e'(code[BASE_W-1:0]);
    signaling = base_signaling(code[BASE_W-1:0]) ^ code[PRED_W-1];
    unique case (base)
      P_EQ:     holds = eq;
      P_LT:     holds = lt;
      P_LE:     holds = lt | eq;
      P_UNORD:  holds = unord;
      P_NE:     holds = unord | ~eq;
      P_NLT:    holds = unord | ~lt;
      P_NLE:    holds = unord | ~(lt | eq);
      P_ORD:    holds = ~unord;
      P_EQ_U:   holds = unord | eq;
      P_NGE:    holds = unord | lt;
      P_NGT:    holds = unord | lt | eq;
      P_NEVER:  holds = 1'b0;
      P_NE_O:   holds = ~unord & ~eq;
      P_GE:     holds = ~unord & ~lt;
      P_GT:     holds = ~unord & ~lt & ~eq;
      P_ALWAYS: holds = 1'b1;
      default:  holds = 1'b0;
    endcase
  end
endmodule

// File: rtl/dpcmp_unit.sv
module dpcmp_unit
  import dpcmp_pkg::*;
#(
  parameter int DEST_W = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              ext_mode,
  input  logic [PRED_W-1:0] pred,
  input  logic [DEST_W-1:0] src_a,
  input  logic [FP_W-1:0]   src_b,
  output logic              out_valid,
  output logic [DEST_W-1:0] result,
  output logic              flag_invalid,
  output logic              flag_denormal
);
  localparam int UP_W   = DEST_W - FP_W;
  localparam int LANE_W = 2 * FP_W;

  fp_class_t         cls [2];
  logic [FP_W-1:0]   ops [2];
  logic [PRED_W-1:0] pred_eff;
  logic              rel_unord, rel_eq, rel_lt;
  logic              pred_holds, pred_signaling;
  logic              snan_any, qnan_any, sub_any;
  logic              next_invalid;
  logic [UP_W-1:0]   upper_ext, upper_next;
  logic [DEST_W-1:0] next_result;

  assign ops[0] = src_a[FP_W-1:0];
  assign ops[1] = src_b;

  for (genvar i = 0; i < 2; i++) begin : g_cls
    dpcmp_classify u_cls (.value(ops[i]), .cls(cls[i]));
  end

  dpcmp_order u_order (
    .a(ops[0]), .b(ops[1]),
    .a_nan(cls[0].is_nan), .b_nan(cls[1].is_nan),
    .a_zero(cls[0].is_zero), .b_zero(cls[1].is_zero),
    .unord(rel_unord), .eq(rel_eq), .lt(rel_lt)
  );

  assign pred_eff = ext_mode ? pred : {{(PRED_W-LEG_W){1'b0}}, pred[LEG_W-1:0]};

  dpcmp_predicate u_pred (
    .code(pred_eff), .unord(rel_unord), .eq(rel_eq), .lt(rel_lt),
    .holds(pred_holds), .signaling(pred_signaling)
  );

  assign snan_any     = cls[0].is_snan | cls[1].is_snan;
  assign qnan_any     = cls[0].is_qnan | cls[1].is_qnan;
  assign sub_any      = cls[0].is_sub  | cls[1].is_sub;
  assign next_invalid = snan_any | (qnan_any & pred_signaling);

  if (DEST_W > LANE_W) begin : g_wide
    assign upper_ext = {{(DEST_W-LANE_W){1'b0}}, src_a[LANE_W-1:FP_W]};
  end else begin : g_exact
    assign upper_ext = src_a[LANE_W-1:FP_W];
  end

  assign upper_next  = ext_mode ? upper_ext : src_a[DEST_W-1:FP_W];
  assign next_result = {upper_next, {FP_W{pred_holds}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      result        <= '0;
      flag_invalid  <= 1'b0;
      flag_denormal <= 1'b0;
    end else begin
      out_valid     <= in_valid;
      flag_invalid  <= in_valid & next_invalid;
      flag_denormal <= in_valid & sub_any;
      if (in_valid) result <= next_result;
    end
  end
endmodule

// File: rtl/dpcmp_unit_chk.sv
module dpcmp_unit_chk
  import dpcmp_pkg::*;
#(
  parameter int DEST_W = 256
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              ext_mode,
  input logic [PRED_W-1:0] pred,
  input logic [DEST_W-1:0] src_a,
  input logic [FP_W-1:0]   src_b,
  input logic              out_valid,
  input logic [DEST_W-1:0] result,
  input logic              flag_invalid,
  input logic              flag_denormal,
  input logic              snan_any,
  input logic              qnan_any,
  input logic              sub_any,
  input logic              pred_signaling,
  input logic              rel_unord,
  input logic              rel_eq,
  input logic              rel_lt
);
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r2_mask_form: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (result[FP_W-1:0] == '0 || result[FP_W-1:0] == '1));
  a_r3_zeros_equal: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !ext_mode && pred[2:0] == 3'd0 &&
    src_a[FP_W-2:0] == '0 && src_b[FP_W-2:0] == '0 |=> result[FP_W-1:0] == '1);
  a_r4_unord_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    rel_unord |-> !rel_eq && !rel_lt);
  a_r5_never_false: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && ext_mode && pred[3:0] == 4'd11 |=> result[FP_W-1:0] == '0);
  a_r7_legacy_upper: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !ext_mode |=> result[DEST_W-1:FP_W] == $past(src_a[DEST_W-1:FP_W]));
  a_r8_ext_lane: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && ext_mode |=> result[2*FP_W-1:FP_W] == $past(src_a[2*FP_W-1:FP_W]));
  if (DEST_W > 2*FP_W) begin : g_clr
    a_r8_ext_clear: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && ext_mode |=> result[DEST_W-1:2*FP_W] == '0);
  end
  a_r9_snan_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && snan_any |=> flag_invalid);
  a_r9_quiet_clean: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !snan_any && !(qnan_any && pred_signaling) |=> !flag_invalid);
  a_r10_denormal: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> flag_denormal == $past(sub_any));
  a_r11_flags_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !flag_invalid && !flag_denormal);
endmodule

bind dpcmp_unit dpcmp_unit_chk #(.DEST_W(DEST_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ext_mode(ext_mode),
  .pred(pred), .src_a(src_a), .src_b(src_b), .out_valid(out_valid),
  .result(result), .flag_invalid(flag_invalid), .flag_denormal(flag_denormal),
  .snan_any(snan_any), .qnan_any(qnan_any), .sub_any(sub_any),
  .pred_signaling(pred_signaling), .rel_unord(rel_unord),
  .rel_eq(rel_eq), .rel_lt(rel_lt)
);

// File: tb/dpcmp_unit_test.sv
module dpcmp_unit_test;
  localparam int W = 256;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         ext_mode = 1'b0;
  logic [4:0]   pred = '0;
  logic [W-1:0] src_a = '0;
  logic [63:0]  src_b = '0;
  logic         out_valid, flag_invalid, flag_denormal;
  logic [W-1:0] result;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  dpcmp_unit #(.DEST_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ext_mode(ext_mode),
    .pred(pred), .src_a(src_a), .src_b(src_b), .out_valid(out_valid),
    .result(result), .flag_invalid(flag_invalid), .flag_denormal(flag_denormal)
  );

  function automatic bit b_nan(input logic [63:0] v);
    return (v[62:52] == 11'h7FF) && (v[51:0] != 0);
  endfunction
  function automatic bit b_snan(input logic [63:0] v);
    return b_nan(v) && !v[51];
  endfunction
  function automatic bit b_sub(input logic [63:0] v);
    return (v[62:52] == 0) && (v[51:0] != 0);
  endfunction
  // Monotonic unsigned key for ordered values; both zeros share a key.
  function automatic logic [63:0] b_key(input logic [63:0] v);
    if (v[62:0] == 0) return 64'h8000_0000_0000_0000;
    return v[63] ? ~v : (v | 64'h8000_0000_0000_0000);
  endfunction

  function automatic bit b_holds(input int code, input logic [63:0] a, input logic [63:0] b);
    bit un, lt, gt, eq;
    un = b_nan(a) || b_nan(b);
    lt = !un && (b_key(a) <  b_key(b));
    gt = !un && (b_key(a) >  b_key(b));
    eq = !un && (b_key(a) == b_key(b));
    case (code % 16)
      0:  return eq;
      1:  return lt;
      2:  return lt || eq;
      3:  return un;
      4:  return un || lt || gt;
      5:  return un || gt || eq;
      6:  return un || gt;
      7:  return !un;
      8:  return un || eq;
      9:  return un || lt;
      10: return un || lt || eq;
      11: return 1'b0;
      12: return lt || gt;
      13: return gt || eq;
      14: return gt;
      default: return 1'b1;
    endcase
  endfunction

  function automatic bit b_sig(input int code);
    bit s;
    case (code % 16)
      0, 3, 4, 7, 8, 11, 12, 15: s = 1'b0;
      default: s = 1'b1;
    endcase
    return s ^ (code >= 16);
  endfunction

  function automatic logic [63:0] gen(input int kind, input logic [63:0] other);
    logic [63:0] r;
    r = {$urandom(), $urandom()};
    case (kind)
      0: r = 64'h0;
      1: r = 64'h8000_0000_0000_0000;
      2: r = {r[63], 11'h7FF, 52'h0};
      3: r = {r[63], 11'h7FF, 1'b1, r[50:0]};
      4: r = {r[63], 11'h7FF, 1'b0, r[50:1], 1'b1};
      5: r = {r[63], 11'h000, r[51:1], 1'b1};
      6: r = other;
      7: r = other + 64'd1;
      8: r = {~other[63], other[62:0]};
      default: if (r[62:52] == 11'h7FF) r[62] = 1'b0;
    endcase
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at a negedge, result registered at the next posedge, sample at the negedge after.
  task automatic run_op(input bit ext, input logic [4:0] p, input logic [W-1:0] a,
                        input logic [63:0] b, input string tag);
    int code;
    logic [63:0] m;
    logic [W-1:0] exp_r;
    bit e_inv, e_den, un_q;
    ext_mode = ext; pred = p; src_a = a; src_b = b; in_valid = 1'b1;
    code  = ext ? int'(p) : int'(p[2:0]);
    m     = b_holds(code, a[63:0], b) ? '1 : '0;
    exp_r = ext ? {128'h0, a[127:64], m} : {a[W-1:64], m};
    un_q  = (b_nan(a[63:0]) && !b_snan(a[63:0])) || (b_nan(b) && !b_snan(b));
    e_inv = b_snan(a[63:0]) || b_snan(b) || (un_q && b_sig(code));
    e_den = b_sub(a[63:0]) || b_sub(b);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, {tag, " R1 valid"}, W'(out_valid), W'(1));
    chk(result[63:0] == m, {tag, ext ? " R5/R6 mask" : " R5 mask"}, W'(result[63:0]), W'(m));
    chk(result[W-1:64] == exp_r[W-1:64], {tag, ext ? " R8 upper" : " R7 upper"},
        result, exp_r);
    chk(flag_invalid == e_inv, {tag, " R9 invalid"}, W'(flag_invalid), W'(e_inv));
    chk(flag_denormal == e_den, {tag, " R10 denormal"}, W'(flag_denormal), W'(e_den));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] wa;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(out_valid == 0 && result == '0 && !flag_invalid && !flag_denormal,
        "R1 reset", result, '0);
    rst_n = 1'b1;
    @(negedge clk);
    wa = {$urandom(), $urandom(), $urandom(), $urandom(),
          $urandom(), $urandom(), $urandom(), $urandom()};
    // R3: -0 equals +0 in both modes
    run_op(1'b0, 5'd0, {wa[W-1:64], 64'h8000_0000_0000_0000}, 64'h0, "R3 zeros");
    run_op(1'b1, 5'd13, {wa[W-1:64], 64'h0}, 64'h8000_0000_0000_0000, "R3 zeros ge");
    // R3: -inf less than +max
    run_op(1'b0, 5'd1, {wa[W-1:64], 64'hFFF0_0000_0000_0000}, 64'h7FEF_FFFF_FFFF_FFFF, "R3 inf");
    // R4: quiet NaN unordered / ordered
    run_op(1'b0, 5'd3, {wa[W-1:64], 64'h7FF8_0000_0000_0000}, 64'h3FF0_0000_0000_0000, "R4 unord");
    run_op(1'b0, 5'd7, {wa[W-1:64], 64'h3FF0_0000_0000_0000}, 64'hBFF0_0000_0000_0000, "R4 ord");
    // R7: legacy ignores bits 4:3 (code 25 acts as 1)
    run_op(1'b0, 5'd25, {wa[W-1:64], 64'h3FF0_0000_0000_0000}, 64'h4000_0000_0000_0000, "R7 bits");
    // R6: code 17 same mask as 1, quiet NaN flags differ (R9)
    run_op(1'b1, 5'd17, {wa[W-1:64], 64'h7FF8_0000_0000_0001}, 64'h0, "R6 q17");
    run_op(1'b1, 5'd1, {wa[W-1:64], 64'h7FF8_0000_0000_0001}, 64'h0, "R9 q1");
    // R9: signaling NaN with quiet predicate
    run_op(1'b1, 5'd0, {wa[W-1:64], 64'h0}, 64'h7FF0_0000_0000_0001, "R9 snan");
    // R10: subnormal operand
    run_op(1'b0, 5'd2, {wa[W-1:64], 64'h0000_0000_0000_0001}, 64'h0, "R10 sub");
    // R5: always false / always true with NaN
    run_op(1'b1, 5'd11, {wa[W-1:64], 64'h7FF8_0000_0000_0000}, 64'h7FF8_0000_0000_0000, "R5 never");
    run_op(1'b1, 5'd31, {wa[W-1:64], 64'h7FF8_0000_0000_0000}, 64'h0, "R5 always");
    // R11: idle cycle clears flags
    @(negedge clk);
    chk(!out_valid && !flag_invalid && !flag_denormal, "R11 idle",
        W'({out_valid, flag_invalid, flag_denormal}), '0);
    // Random mix, R2 covered by mask checks
    for (int i = 0; i < 4000; i++) begin
      logic [63:0] a0, b0;
      logic [W-1:0] aw;
      a0 = gen(int'($urandom_range(0, 12)), 64'h3FF0_0000_0000_0000);
      b0 = gen(int'($urandom_range(0, 12)), a0);
      aw = {$urandom(), $urandom(), $urandom(), $urandom(),
            $urandom(), $urandom(), a0};
      run_op(1'($urandom_range(0, 1)), 5'($urandom_range(0, 31)), aw, b0, "R2 rand");
      if ($urandom_range(0, 7) == 0) @(negedge clk);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule